// File: doc/BRIEF.md
# MSI Termination Register Bank

This block terminates inbound message-signalled interrupt writes and turns each one into a pending bit. Vectors are organised as a two-level hierarchy: a number of groups, each holding several index registers of vector bits, plus one summary word per group that shows which of its index registers currently hold anything. Each group owns one level-sensitive interrupt line, so a downstream interrupt controller sees one request per group rather than one flat pending word.

An inbound write carries a byte offset and a data value. The offset selects a group and an index register, and the data value selects the bit to set. The inbound port uses valid/ready, but `msi_ready` is held high at all times outside reset, so the sender never sees back-pressure and every cycle with `msi_valid` high is an accepted write. Software drains pending work through a plain 32-bit read port with one cycle of latency. Reading an index register returns its bits and empties it. Reading a summary word has no side effect. Writes that fall outside the index map, or that name a bit past the top of a register, are discarded and leave a sticky error flag that software reads and clears.

Top module: `msi_term_bank`

## Requirements
- R1: After reset every index register is empty, every `irq` bit is 0, every summary word reads 0 and the error word reads 0.
- R2: A write with `msi_valid` high, offset `(g << 19) | (i << 16)` and data `d` below 16 sets bit `d` of index register `i` in group `g`. `msi_ready` is always 1 and writes are never stalled.
- R3: The summary word of group `g` is read at offset `0x800000 | (g << 16)`. Bit `i` of it is 1 exactly when index register `i` of that group is non-zero. Reading it changes no state.
- R4: `irq[g]` is 1 exactly when group `g` has at least one pending bit. It follows a write in the cycle after that write is accepted.
- R5: A read with `rd_en` high returns data one cycle later with `rd_valid` high. An index read returns the register's bits in `rd_data[15:0]` with the upper bits zero, and it leaves that register empty.
- R6: When a write sets a bit in the same cycle that a read clears that same index register, the read returns the old contents and the register keeps only the newly written bit.
- R7: A write is dropped if its offset has non-zero bits 15:0, lies at or above `0x800000`, or carries data of 16 or more. A dropped write changes no pending bit and sets the error flag.
- R8: The error word at offset `0x900000` returns the flag in bit 0, and reading it clears the flag. An error raised in the same cycle as that read survives the read.
- R9: Once every index register of every group has been read, every summary word reads 0 and every `irq` bit is 0.
- R10: A read of any other offset returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msi_valid | input | 1 | Inbound write strobe |
| msi_ready | output | 1 | Write acceptance, held at 1 outside reset |
| msi_addr | input | ADDR_W (24) | Byte offset of the inbound write |
| msi_data | input | 32 | Vector bit number of the inbound write |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W (24) | Byte offset of the register to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| irq | output | N_GRP (16) | Per-group level interrupt |

## Verification
An inbound write and a read-to-clear can target the same index register in the same cycle. So can a rejected write and a read of the error word. The bench provokes both by driving `msi_valid` and `rd_en` together at the same negative clock edge. It judges the collision in two steps: the returned word must hold only the old contents, and a second read must then return exactly the newly set bit, or a still-set error flag.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  // Register words are 64 KiB apart; bits below this are always zero
  localparam int WORD_LSB = 16;
  localparam int DATA_W   = 32;

  typedef enum logic [1:0] {
    RK_NONE    = 2'd0,
    RK_INDEX   = 2'd1,
    RK_SUMMARY = 2'd2,
    RK_ERROR   = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/msi_wr_decode.sv
module msi_wr_decode
  import msi_term_pkg::*;
#(
  parameter int N_GRP  = 16,
  parameter int N_IDX  = 8,
  parameter int VEC    = 16,
  parameter int ADDR_W = 24
) (
  input  logic                       wr_fire,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [N_GRP-1:0]           set_grp_oh,
  output logic [$clog2(N_IDX)-1:0]   set_idx,
  output logic [VEC-1:0]             set_bits,
  output logic                       wr_bad
);
  localparam int GRP_W  = $clog2(N_GRP);
  localparam int IDX_W  = $clog2(N_IDX);
  localparam int VEC_W  = $clog2(VEC);
  localparam int MAP_HI = WORD_LSB + IDX_W + GRP_W;

  logic             in_map;
  logic             data_ok;
  logic [GRP_W-1:0] grp;

  always_comb begin
    in_map   = ((wr_addr >> MAP_HI) == '0) && (wr_addr[WORD_LSB-1:0] == '0);
    data_ok  = (wr_data < DATA_W'(VEC));
    grp      = wr_addr[WORD_LSB+IDX_W +: GRP_W];
    set_idx  = wr_addr[WORD_LSB +: IDX_W];
    set_bits = VEC'(1) << wr_data[VEC_W-1:0];
    wr_bad   = wr_fire && !(in_map && data_ok);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_sel
    assign set_grp_oh[g] = wr_fire && in_map && data_ok && (grp == GRP_W'(g));
  end
endmodule

// File: rtl/msi_group.sv
module msi_group #(
  parameter int N_IDX = 8,
  parameter int VEC   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic [$clog2(N_IDX)-1:0] set_idx,
  input  logic [VEC-1:0]           set_bits,
  input  logic                     clr_en,
  input  logic [$clog2(N_IDX)-1:0] clr_idx,
  output logic [N_IDX*VEC-1:0]     idx_vals,
  output logic [N_IDX-1:0]         summary,
  output logic                     irq
);
  localparam int IDX_W = $clog2(N_IDX);

  for (genvar i = 0; i < N_IDX; i++) begin : g_idx
    logic [VEC-1:0] pend_q;
    logic           set_hit;
    logic           clr_hit;

    assign set_hit = set_en && (set_idx == IDX_W'(i));
    assign clr_hit = clr_en && (clr_idx == IDX_W'(i));

    // Clear first, then merge the new bit, so a same-cycle set survives
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
      end else if (set_hit || clr_hit) begin
        pend_q <= (pend_q & ~{VEC{clr_hit}}) | (set_hit ? set_bits : '0);
      end
    end

    assign idx_vals[i*VEC +: VEC] = pend_q;
    assign summary[i]             = |pend_q;
  end

  assign irq = |summary;
endmodule

// File: rtl/msi_rd_port.sv
module msi_rd_port
  import msi_term_pkg::*;
#(
  parameter int N_GRP  = 16,
  parameter int N_IDX  = 8,
  parameter int VEC    = 16,
  parameter int ADDR_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [N_GRP*N_IDX*VEC-1:0] all_vals,
  input  logic [N_GRP*N_IDX-1:0]     all_sums,
  input  logic                       err_flag,
  output logic [N_GRP-1:0]           clr_grp_oh,
  output logic [$clog2(N_IDX)-1:0]   clr_idx,
  output logic                       err_clr,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int GRP_W   = $clog2(N_GRP);
  localparam int IDX_W   = $clog2(N_IDX);
  localparam int MAP_HI  = WORD_LSB + IDX_W + GRP_W;
  localparam int SUM_LSB = WORD_LSB + GRP_W;
  localparam logic [ADDR_W-1:0] SUM_TAG  = ADDR_W'(1) << IDX_W;
  localparam logic [ADDR_W-1:0] ERR_ADDR = (SUM_TAG + ADDR_W'(1)) << SUM_LSB;

  rd_kind_e                kind;
  logic [GRP_W-1:0]        idx_grp;
  logic [GRP_W-1:0]        sum_grp;
  logic [GRP_W+IDX_W-1:0]  word_sel;
  logic [VEC-1:0]          idx_word;
  logic [N_IDX-1:0]        sum_word;
  logic [DATA_W-1:0]       rd_next;

  always_comb begin
    idx_grp = rd_addr[WORD_LSB+IDX_W +: GRP_W];
    sum_grp = rd_addr[WORD_LSB +: GRP_W];
    clr_idx = rd_addr[WORD_LSB +: IDX_W];
    kind    = RK_NONE;
    if (rd_addr[WORD_LSB-1:0] == '0) begin
      if ((rd_addr >> MAP_HI) == '0)              kind = RK_INDEX;
      else if ((rd_addr >> SUM_LSB) == SUM_TAG)   kind = RK_SUMMARY;
      else if (rd_addr == ERR_ADDR)               kind = RK_ERROR;
    end
    word_sel = {idx_grp, clr_idx};
    idx_word = all_vals[word_sel*VEC +: VEC];
    sum_word = all_sums[sum_grp*N_IDX +: N_IDX];
    case (kind)
      RK_INDEX:   rd_next = DATA_W'(idx_word);
      RK_SUMMARY: rd_next = DATA_W'(sum_word);
      RK_ERROR:   rd_next = DATA_W'(err_flag);
      default:    rd_next = '0;
    endcase
    err_clr = rd_en && (kind == RK_ERROR);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_clr
    assign clr_grp_oh[g] = rd_en && (kind == RK_INDEX) && (idx_grp == GRP_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
#(
  parameter int N_GRP  = 16,
  parameter int N_IDX  = 8,
  parameter int VEC    = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [ADDR_W-1:0] msi_addr,
  input  logic [31:0]       msi_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [N_GRP-1:0]  irq
);
  localparam int IDX_W  = $clog2(N_IDX);
  localparam int GRP_VW = N_IDX * VEC;

  logic [N_GRP-1:0]         set_grp_oh;
  logic [IDX_W-1:0]         set_idx;
  logic [VEC-1:0]           set_bits;
  logic                     wr_bad;
  logic [N_GRP-1:0]         clr_grp_oh;
  logic [IDX_W-1:0]         clr_idx;
  logic                     err_clr;
  logic                     err_q;
  logic [N_GRP*GRP_VW-1:0]  all_vals;
  logic [N_GRP*N_IDX-1:0]   all_sums;
  logic                     ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign msi_ready = ready_q;

  msi_wr_decode #(
    .N_GRP(N_GRP), .N_IDX(N_IDX), .VEC(VEC), .ADDR_W(ADDR_W)
  ) wr_dec_i (
    .wr_fire    (msi_valid && msi_ready),
    .wr_addr    (msi_addr),
    .wr_data    (msi_data),
    .set_grp_oh (set_grp_oh),
    .set_idx    (set_idx),
    .set_bits   (set_bits),
    .wr_bad     (wr_bad)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    msi_group #(.N_IDX(N_IDX), .VEC(VEC)) grp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_grp_oh[g]),
      .set_idx  (set_idx),
      .set_bits (set_bits),
      .clr_en   (clr_grp_oh[g]),
      .clr_idx  (clr_idx),
      .idx_vals (all_vals[g*GRP_VW +: GRP_VW]),
      .summary  (all_sums[g*N_IDX +: N_IDX]),
      .irq      (irq[g])
    );
  end

  // Sticky error: a new error wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (err_q && !err_clr) || wr_bad;
  end

  msi_rd_port #(
    .N_GRP(N_GRP), .N_IDX(N_IDX), .VEC(VEC), .ADDR_W(ADDR_W)
  ) rd_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .all_vals   (all_vals),
    .all_sums   (all_sums),
    .err_flag   (err_q),
    .clr_grp_oh (clr_grp_oh),
    .clr_idx    (clr_idx),
    .err_clr    (err_clr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/msi_term_bank_chk.sv
module msi_term_bank_chk #(
  parameter int N_GRP  = 16,
  parameter int N_IDX  = 8,
  parameter int VEC    = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_valid,
  input logic              msi_ready,
  input logic [ADDR_W-1:0] msi_addr,
  input logic [31:0]       msi_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [N_GRP-1:0]  irq
);
  localparam int GRP_W  = $clog2(N_GRP);
  localparam int IDX_W  = $clog2(N_IDX);
  localparam int MAP_HI = 16 + IDX_W + GRP_W;

  logic             w_ok;
  logic [GRP_W-1:0] w_grp;
  logic             r_idx;

  assign w_ok  = ((msi_addr >> MAP_HI) == '0) && (msi_addr[15:0] == '0) &&
                 (msi_data < 32'(VEC));
  assign w_grp = msi_addr[16+IDX_W +: GRP_W];
  assign r_idx = ((rd_addr >> MAP_HI) == '0) && (rd_addr[15:0] == '0);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (irq == '0 && !rd_valid);
    end
  end

  // R2
  accept_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_ready && w_ok) |=> irq[$past(w_grp)]);

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R5
  idx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && r_idx) |=> (rd_data[31:VEC] == '0));

  // R7
  drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !w_ok && !rd_en) |=> $stable(irq));
endmodule

bind msi_term_bank msi_term_bank_chk #(
  .N_GRP(N_GRP), .N_IDX(N_IDX), .VEC(VEC), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
  .msi_addr(msi_addr), .msi_data(msi_data), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
);

// File: tb/msi_term_bank_tb_top.sv
module msi_term_bank_tb_top;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              msi_valid = 1'b0;
  logic              msi_ready;
  logic [ADDR_W-1:0] msi_addr = '0;
  logic [31:0]       msi_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic [15:0]       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  msi_term_bank dut_i (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] ia(int g, int i);
    return (ADDR_W'(g) << 19) | (ADDR_W'(i) << 16);
  endfunction

  function automatic logic [ADDR_W-1:0] sa(int g);
    return 24'h800000 | (ADDR_W'(g) << 16);
  endfunction

  localparam logic [ADDR_W-1:0] ERR_A = 24'h900000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check("R5 rd_valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'h0);
    check("R2 ready", 32'(msi_ready), 32'd1);
    for (int g = 0; g < 16; g++) begin
      rd(sa(g), d);
      check("R1 summary", d, 32'h0);
    end
    rd(ia(9, 3), d);
    check("R1 index", d, 32'h0);
    rd(ERR_A, d);
    check("R1 error", d, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(ia(3, 2), 32'd5);
    check("R4 irq after set", 32'(irq), 32'h0008);
    rd(sa(3), d);
    check("R3 summary", d, 32'h04);
    rd(sa(3), d);
    check("R3 summary reread", d, 32'h04);
    rd(ia(3, 2), d);
    check("R5 index value", d, 32'h0020);
    check("R4 irq after clear", 32'(irq), 32'h0);
    rd(ia(3, 2), d);
    check("R5 index cleared", d, 32'h0);
    rd(sa(3), d);
    check("R3 summary cleared", d, 32'h0);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    wr(ia(0, 0), 32'd0);
    wr(ia(0, 7), 32'd15);
    wr(ia(15, 7), 32'd15);
    wr(ia(15, 0), 32'd3);
    wr(ia(15, 0), 32'd3);
    check("R4 two groups", 32'(irq), 32'h8001);
    rd(sa(0), d);
    check("R3 group0", d, 32'h81);
    rd(sa(15), d);
    check("R3 group15", d, 32'h81);
    rd(ia(15, 7), d);
    check("R2 top bit", d, 32'h8000);
    rd(sa(15), d);
    check("R3 partial", d, 32'h01);
    rd(ia(15, 0), d);
    check("R2 repeat set", d, 32'h0008);
    check("R4 group15 low", 32'(irq), 32'h0001);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(ia(5, 4), 32'd1);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ia(5, 4);
    msi_valid = 1'b1; msi_addr = ia(5, 4); msi_data = 32'd9;
    @(negedge clk);
    rd_en = 1'b0; msi_valid = 1'b0;
    check("R6 old value", rd_data, 32'h0002);
    check("R6 irq kept", 32'(irq[5]), 32'd1);
    rd(ia(5, 4), d);
    check("R6 new bit kept", d, 32'h0200);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    logic [15:0] irq_before;
    wr(ia(2, 1), 32'd4);
    irq_before = irq;
    wr(24'h010004, 32'd1);
    check("R7 low bits no effect", 32'(irq), 32'(irq_before));
    rd(ERR_A, d);
    check("R8 flag set", d, 32'h1);
    rd(ERR_A, d);
    check("R8 flag cleared", d, 32'h0);
    wr(24'h800000, 32'd0);
    check("R7 summary write dropped", 32'(irq), 32'(irq_before));
    rd(ERR_A, d);
    check("R7 summary write flag", d, 32'h1);
    wr(ia(7, 0), 32'd16);
    check("R7 data16 no irq", 32'(irq[7]), 32'd0);
    rd(ia(7, 0), d);
    check("R7 data16 no bit", d, 32'h0);
    rd(ia(2, 1), d);
    check("R7 other reg intact", d, 32'h0010);
    // error read collides with a new error
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ERR_A;
    msi_valid = 1'b1; msi_addr = 24'h000100; msi_data = 32'd0;
    @(negedge clk);
    rd_en = 1'b0; msi_valid = 1'b0;
    check("R8 collide old", rd_data, 32'h1);
    rd(ERR_A, d);
    check("R8 collide survives", d, 32'h1);
    rd(ERR_A, d);
    check("R8 collide cleared", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(ia(11, 6), 32'd7);
    rd(24'h900004, d);
    check("R10 unmapped zero", d, 32'h0);
    rd(24'hA00000, d);
    check("R10 unmapped high", d, 32'h0);
    rd(sa(11), d);
    check("R10 no side effect", d, 32'h40);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int g = 0; g < 16; g += 3) wr(ia(g, g % 8), 32'(g));
    wr(ia(14, 5), 32'd2);
    for (int g = 0; g < 16; g++)
      for (int i = 0; i < 8; i++) rd(ia(g, i), d);
    check("R9 irq all low", 32'(irq), 32'h0);
    for (int g = 0; g < 16; g++) begin
      rd(sa(g), d);
      check("R9 summary zero", d, 32'h0);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_multi();
    t_collide();
    t_errors();
    t_unmapped();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule